// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps an effective address onto a real address through a small bank of block-mapping entries. Each entry is a pair of registers. The upper register holds the effective block base, a block-length code and two enable bits, one for supervisor mode and one for user mode. The lower register holds the real block base and a 2-bit access-rights code.

Lookup is purely combinational. The core presents an address, an access kind and its current privilege mode. In the same cycle the block answers with a hit flag, the translated real address and a protection-fault flag. Configuration is held in flip-flops and is loaded through a field-oriented write port. A chip uses one instance for instruction fetches and a separate instance for data accesses. Anything that misses here goes on to a slower translation path outside this block.

Top module: `bat_matcher`

## Requirements
- R1: After reset every entry is disabled in both modes, so `hit` stays 0 for any address until an entry with a set enable bit is written.
- R2: `wrVal[1]` enables an entry for supervisor lookups (`userMode`=0). `wrVal[0]` enables it for user lookups (`userMode`=1). An entry whose enable bit for the current mode is clear never matches.
- R3: The offset mask of an entry is the 11-bit length code placed directly above 17 low ones. Code 0 gives a 128 KB block. Each set length bit doubles the pass-through range.
- R4: An entry matches when the effective address ANDed with the inverted offset mask equals the stored effective base shifted up by 17. A stored base with bits inside the offset range never matches.
- R5: On a hit, `realAddr` equals the effective address ANDed with the offset mask, ORed with the stored real base shifted up by 17.
- R6: Access kinds are encoded on `accType` as 0 read, 1 write, 2 fetch, 3 (treated as read). Rights code 00 denies every kind. Codes 01 and 11 deny writes only. Code 10 permits every kind.
- R7: When several enabled entries match, the lowest-numbered one supplies the real base and the rights code.
- R8: A denied access drives `protFault`=1 while `hit` stays 1. `realAddr` is then undefined. A miss drives both `hit` and `protFault` to 0.
- R9: While `wrEn` is 1 at a rising clock edge, entry `wrIdx` is loaded. If `wrUpper`=1, its base, length and enables are loaded from `wrBase`, `wrLen` and `wrVal`. If `wrUpper`=0, its real base and rights are loaded from `wrBase` and `wrProt`. The new value affects lookups from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Configuration write strobe |
| wrIdx | input | 2 | Entry selected for the write |
| wrUpper | input | 1 | 1 loads the upper register, 0 loads the lower register |
| wrBase | input | 15 | Effective base (upper) or real base (lower), address bits 31..17 |
| wrLen | input | 11 | Block-length code (upper only) |
| wrVal | input | 2 | Enables: bit 1 supervisor, bit 0 user (upper only) |
| wrProt | input | 2 | Access-rights code (lower only) |
| effAddr | input | 32 | Effective address to translate |
| accType | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| userMode | input | 1 | 1 for user mode, 0 for supervisor mode |
| hit | output | 1 | An enabled entry matches |
| realAddr | output | 32 | Translated address, valid when hit=1 and protFault=0 |
| protFault | output | 1 | Matching entry denies this access kind |

## Verification
The bench builds the block with its default parameters: a 32-bit address, four entries and a 17-bit minimum offset. These values make the top four address bits always compared, even with the length code at its maximum of 0x7FF. They also keep the overlap-priority cases small enough to enumerate by hand. Random configurations reuse a few effective bases, so entries often overlap and the lowest-index rule is exercised many times.

// File: rtl/bat_pkg.sv
package bat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } accKind_e;

  localparam logic [1:0] RIGHTS_NONE = 2'b00;
  localparam logic [1:0] RIGHTS_ALL  = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadUpper;
    logic       loadLower;
    logic [7:0] pairIdx;
  } cfgStrobe_t;

endpackage

// File: rtl/bat_ctrl.sv
module bat_ctrl
  import bat_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrUpper,
  output cfgStrobe_t       strb
);

  logic inRange;

  always_comb begin
    inRange        = (32'(wrIdx) < NUM_PAIRS);
    strb.loadUpper = wrEn && wrUpper && inRange;
    strb.loadLower = wrEn && !wrUpper && inRange;
    strb.pairIdx   = 8'(wrIdx);
  end

endmodule

// File: rtl/bat_datapath.sv
module bat_datapath
  import bat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_PAIRS = 4,
  parameter int OFF_W     = 17,
  parameter int BL_W      = 11,
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int IDX_W  = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [PAGE_W-1:0] wrBase,
  input  logic [BL_W-1:0]   wrLen,
  input  logic [1:0]        wrVal,
  input  logic [1:0]        wrProt,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [1:0]        accType,
  input  logic              userMode,
  output logic              hit,
  output logic [ADDR_W-1:0] realAddr,
  output logic              protFault
);

  logic [PAGE_W-1:0] effBaseQ [NUM_PAIRS];
  logic [BL_W-1:0]   lenQ     [NUM_PAIRS];
  logic [1:0]        valQ     [NUM_PAIRS];
  logic [PAGE_W-1:0] realBaseQ[NUM_PAIRS];
  logic [1:0]        rightsQ  [NUM_PAIRS];

  logic [ADDR_W-1:0]    offMask[NUM_PAIRS];
  logic [NUM_PAIRS-1:0] pairHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PAIRS; i++) begin
        effBaseQ[i]  <= '0;
        lenQ[i]      <= '0;
        valQ[i]      <= '0;
        realBaseQ[i] <= '0;
        rightsQ[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_PAIRS; i++) begin
        if (strb.loadUpper && strb.pairIdx == 8'(i)) begin
          effBaseQ[i] <= wrBase;
          lenQ[i]     <= wrLen;
          valQ[i]     <= wrVal;
        end
        if (strb.loadLower && strb.pairIdx == 8'(i)) begin
          realBaseQ[i] <= wrBase;
          rightsQ[i]   <= wrProt;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    logic modeOn;
    assign offMask[g]  = ADDR_W'({lenQ[g], {OFF_W{1'b1}}});
    assign modeOn      = userMode ? valQ[g][0] : valQ[g][1];
    assign pairHit[g]  = modeOn &&
                         ((effAddr & ~offMask[g]) == {effBaseQ[g], {OFF_W{1'b0}}});
  end

  logic [IDX_W-1:0] selIdx;
  logic [1:0]       selRights;

  always_comb begin
    selIdx = '0;
    for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
      if (pairHit[i]) selIdx = IDX_W'(i);
    end
    selRights = rightsQ[selIdx];
    hit       = |pairHit;
    realAddr  = (effAddr & offMask[selIdx]) | {realBaseQ[selIdx], {OFF_W{1'b0}}};
    protFault = hit && ((selRights == RIGHTS_NONE) ||
                        ((accType == ACC_WRITE) && (selRights != RIGHTS_ALL)));
  end

endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
  import bat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_PAIRS = 4,
  parameter int OFF_W     = 17,
  parameter int BL_W      = 11,
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int IDX_W  = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrUpper,
  input  logic [PAGE_W-1:0] wrBase,
  input  logic [BL_W-1:0]   wrLen,
  input  logic [1:0]        wrVal,
  input  logic [1:0]        wrProt,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [1:0]        accType,
  input  logic              userMode,
  output logic              hit,
  output logic [ADDR_W-1:0] realAddr,
  output logic              protFault
);

  cfgStrobe_t strb;

  bat_ctrl #(.NUM_PAIRS(NUM_PAIRS)) u_ctrl (
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrUpper(wrUpper),
    .strb   (strb)
  );

  bat_datapath #(
    .ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS), .OFF_W(OFF_W), .BL_W(BL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrBase   (wrBase),
    .wrLen    (wrLen),
    .wrVal    (wrVal),
    .wrProt   (wrProt),
    .effAddr  (effAddr),
    .accType  (accType),
    .userMode (userMode),
    .hit      (hit),
    .realAddr (realAddr),
    .protFault(protFault)
  );

endmodule

// File: rtl/bat_matcher_checker.sv
module bat_matcher_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrUpper,
  input logic [1:0]        wrVal,
  input logic [ADDR_W-1:0] effAddr,
  input logic [1:0]        accType,
  input logic              userMode,
  input logic              hit,
  input logic [ADDR_W-1:0] realAddr,
  input logic              protFault
);

  logic seenEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenEnable <= 1'b0;
    else if (wrEn && wrUpper && (|wrVal)) seenEnable <= 1'b1;
  end

  // R1: nothing can hit before any entry has been enabled
  a_r1_no_hit_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !seenEnable |-> !hit);

  // R8: a fault is only reported on a matching access
  a_r8_fault_implies_hit: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> hit);

  // R5: the in-block offset passes through untouched
  a_r5_offset_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !protFault) |-> (realAddr[OFF_W-1:0] == effAddr[OFF_W-1:0]));

  // R9: without a write the lookup answer depends only on its inputs
  a_r9_config_held: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!wrEn) && $stable(effAddr) && $stable(accType) && $stable(userMode))
      |-> ($stable(hit) && $stable(protFault)));

endmodule

bind bat_matcher bat_matcher_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrUpper  (wrUpper),
  .wrVal    (wrVal),
  .effAddr  (effAddr),
  .accType  (accType),
  .userMode (userMode),
  .hit      (hit),
  .realAddr (realAddr),
  .protFault(protFault)
);

// File: tb/test_bat_matcher.sv
module test_bat_matcher;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic        wrUpper = 1'b0;
  logic [14:0] wrBase = '0;
  logic [10:0] wrLen = '0;
  logic [1:0]  wrVal = '0;
  logic [1:0]  wrProt = '0;
  logic [31:0] effAddr = '0;
  logic [1:0]  accType = '0;
  logic        userMode = 1'b0;
  logic        hit;
  logic [31:0] realAddr;
  logic        protFault;

  int testsRun = 0;
  int testsFailed = 0;

  logic [14:0] mEff[4];
  logic [10:0] mLen[4];
  logic [1:0]  mVal[4];
  logic [14:0] mReal[4];
  logic [1:0]  mProt[4];

  always #5 clk = ~clk;

  bat_matcher i_bat_matcher (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrUpper(wrUpper),
    .wrBase(wrBase), .wrLen(wrLen), .wrVal(wrVal), .wrProt(wrProt),
    .effAddr(effAddr), .accType(accType), .userMode(userMode),
    .hit(hit), .realAddr(realAddr), .protFault(protFault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeUpper(input int idx, input logic [14:0] base,
                            input logic [10:0] len, input logic [1:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrUpper = 1'b1; wrIdx = 2'(idx);
    wrBase = base; wrLen = len; wrVal = val; wrProt = 2'($urandom);
    @(negedge clk);
    wrEn = 1'b0;
    mEff[idx] = base; mLen[idx] = len; mVal[idx] = val;
  endtask

  task automatic writeLower(input int idx, input logic [14:0] base, input logic [1:0] prot);
    @(negedge clk);
    wrEn = 1'b1; wrUpper = 1'b0; wrIdx = 2'(idx);
    wrBase = base; wrProt = prot; wrLen = 11'($urandom); wrVal = 2'($urandom);
    @(negedge clk);
    wrEn = 1'b0;
    mReal[idx] = base; mProt[idx] = prot;
  endtask

  // Model of R2..R8 computed from the requirement text
  task automatic lookup(input string req, input logic [31:0] ea,
                        input logic [1:0] acc, input logic usr);
    logic        eHit, eFault;
    logic [31:0] eRa, mask;
    eHit = 1'b0; eFault = 1'b0; eRa = '0;
    for (int i = 0; i < 4; i++) begin
      mask = 32'({mLen[i], 17'h1FFFF});
      if (!eHit && (usr ? mVal[i][0] : mVal[i][1]) &&
          ((ea & ~mask) == {mEff[i], 17'h0})) begin
        eHit = 1'b1;
        eRa = (ea & mask) | {mReal[i], 17'h0};
        eFault = (mProt[i] == 2'b00) || (acc == 2'd1 && mProt[i] != 2'b10);
      end
    end
    @(negedge clk);
    effAddr = ea; accType = acc; userMode = usr;
    #2;
    check({req, " hit"}, 32'(hit), 32'(eHit));
    check({req, " fault"}, 32'(protFault), 32'(eFault));
    if (eHit && !eFault) check({req, " realAddr"}, realAddr, eRa);
  endtask

  initial begin
    #200000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4; i++) begin
      mEff[i] = '0; mLen[i] = '0; mVal[i] = '0; mReal[i] = '0; mProt[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: empty after reset
    lookup("R1 reset sup", 32'h0000_0000, 2'd0, 1'b0);
    lookup("R1 reset usr", 32'h0000_1000, 2'd2, 1'b1);

    // R9 / R2: supervisor-only 128 KB block
    writeUpper(0, 15'h0001, 11'h000, 2'b10);
    writeLower(0, 15'h0100, 2'b10);
    lookup("R2 sup enabled", 32'h0002_1234, 2'd0, 1'b0);
    check("R5 literal realAddr", realAddr, 32'h0200_1234);
    lookup("R2 usr disabled", 32'h0002_1234, 2'd0, 1'b1);
    lookup("R3 128KB edge", 32'h0004_1234, 2'd0, 1'b0);

    // R3 / R4: largest block, stored base with low bits inside mask
    writeUpper(1, 15'h1000, 11'h7FF, 2'b11);
    writeLower(1, 15'h4000, 2'b10);
    lookup("R3 max block", 32'h2ABC_DEF0, 2'd2, 1'b1);
    writeUpper(2, 15'h0013, 11'h003, 2'b11);
    writeLower(2, 15'h0200, 2'b10);
    lookup("R4 base inside mask", 32'h0026_0000, 2'd0, 1'b0);
    writeUpper(2, 15'h0010, 11'h003, 2'b11);
    lookup("R4 aligned base", 32'h0027_FFFC, 2'd0, 1'b0);

    // R6 / R8: every rights code against every access kind
    for (int p = 0; p < 4; p++) begin
      writeLower(1, 15'h4000, 2'(p));
      for (int a = 0; a < 4; a++) lookup("R6 rights", 32'h2000_0040, 2'(a), 1'b0);
    end
    writeLower(1, 15'h4000, 2'b00);
    lookup("R8 fault keeps hit", 32'h2000_0040, 2'd0, 1'b1);
    check("R8 hit stays high", 32'(hit), 32'd1);

    // R7: overlapping entries, lowest index wins
    writeUpper(3, 15'h1000, 11'h001, 2'b11);
    writeLower(3, 15'h6000, 2'b10);
    writeUpper(1, 15'h1000, 11'h001, 2'b11);
    writeLower(1, 15'h5000, 2'b01);
    lookup("R7 low index wins", 32'h2001_0010, 2'd1, 1'b0);
    lookup("R7 low index read", 32'h2001_0010, 2'd0, 1'b0);
    writeUpper(1, 15'h1000, 11'h001, 2'b00);
    lookup("R7 fallthrough", 32'h2001_0010, 2'd1, 1'b0);

    // Random configurations and lookups
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < 4; i++) begin
        logic [14:0] b;
        b = ($urandom % 2) ? 15'h1000 : 15'($urandom);
        writeUpper(i, b, 11'($urandom % 8), 2'($urandom));
        writeLower(i, 15'($urandom), 2'($urandom));
      end
      for (int k = 0; k < 12; k++) begin
        logic [31:0] ea;
        ea = 32'($urandom);
        if ($urandom % 2) ea = {mEff[$urandom % 4], 17'($urandom)};
        lookup("R4 R5 R6 R7 random", ea, 2'($urandom), 1'($urandom));
      end
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule